// File: doc/BRIEF.md
# Asynchronous Static RAM Bus Controller

This block connects a clocked host inside the chip to an external 64K x 16 asynchronous static RAM. The host issues one access at a time on a request port. The port carries an address, a write word, a read/write flag and a two-bit byte-lane enable. The controller turns each request into the RAM's active-low strobes: chip select, write strobe, output strobe and two lane strobes. Every access is held for a number of clock cycles set by parameters. These are sized so that the number of cycles times the clock period covers the RAM's 15 ns access and cycle times.

All pins on the memory side come from registers, so the strobes cannot glitch. The shared data bus is split into three signals: a driver enable, the outgoing word and the incoming word. The controller turns its drivers on only while the RAM's output strobe is high. After every read it inserts a turnaround gap before it accepts the next request. A write is committed by the rising edge of the write strobe. Address and data stay unchanged for one hold cycle after that edge. When no access is running, the chip select is held high so the RAM stays in standby.

The state machine has five states. IDLE waits for a request. RD_ACTIVE holds a read. WR_ACTIVE holds the write strobe low. WR_RELEASE raises the write strobe while address and data are held. TURNAROUND keeps every strobe high after a read.

The transitions are as follows:
- IDLE goes to RD_ACTIVE or WR_ACTIVE when a request arrives with at least one lane enabled.
- A request with no lanes enabled stays in IDLE and returns its result one cycle later.
- RD_ACTIVE goes to TURNAROUND when its counter expires.
- WR_ACTIVE goes to WR_RELEASE when its counter expires.
- WR_RELEASE goes to IDLE after one cycle.
- TURNAROUND goes to IDLE when its counter expires.

Top module: `sram_bus_ctrl`

## Requirements
- R1: After reset, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n and sram_ub_n are all 1, sram_dq_oe is 0 and req_ready is 1.
- R2: A request is taken only in a cycle where req_ready is 1. Whenever req_ready is 1, sram_ce_n is 1.
- R3: A read with at least one lane holds sram_ce_n=0, sram_oe_n=0 and sram_we_n=1 for exactly RD_CYCLES clock cycles. At the end of that window the controller samples sram_dq_in and presents the word on rd_data with a one-cycle rd_valid pulse.
- R4: A write with at least one lane holds sram_ce_n=0 and sram_we_n=0 for exactly WR_CYCLES cycles, with sram_oe_n=1 throughout. Then sram_we_n rises while sram_ce_n, sram_addr, sram_dq_out and sram_dq_oe stay unchanged for one cycle. After that the strobes are released and ack pulses for one cycle.
- R5: Lane strobes are active low. sram_lb_n = ~req_be[0] and gates bits 7:0. sram_ub_n = ~req_be[1] and gates bits 15:8. Both hold for the whole access, on reads and on writes. Both are 1 whenever sram_ce_n is 1.
- R6: On a read, the bits of rd_data belonging to a lane that was not enabled are 0.
- R7: sram_dq_oe is never 1 in a cycle where sram_oe_n is 0.
- R8: After a read, all strobes stay high and req_ready stays 0 for TURN_CYCLES cycles. So at least TURN_CYCLES+1 cycles lie between the last cycle with sram_oe_n=0 and the first cycle with sram_dq_oe=1.
- R9: A write with req_be=0 pulses ack in the cycle after acceptance, never drives sram_we_n low and leaves the memory contents unchanged.
- R10: A read with req_be=0 pulses rd_valid in the cycle after acceptance with rd_data=0, and never drives sram_oe_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Host request, taken when req_ready is 1 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Controller idle and able to take a request |
| ack | output | 1 | One-cycle write completion pulse |
| rd_valid | output | 1 | One-cycle read result pulse |
| rd_data | output | 16 | Read word, unselected lanes zero |
| sram_addr | output | 16 | RAM address bus |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output strobe, active low |
| sram_lb_n | output | 1 | Low-lane strobe, active low |
| sram_ub_n | output | 1 | High-lane strobe, active low |
| sram_dq_oe | output | 1 | Controller data driver enable |
| sram_dq_out | output | 16 | Data driven toward the RAM |
| sram_dq_in | input | 16 | Data read from the RAM pins |

## Verification
The bound checker tests several properties on every cycle. It checks that the controller drivers and the RAM output strobe are never both active. It checks that chip select stays high while the controller is idle and that the lane strobes are released whenever chip select is. It checks that address and data hold still across the rising write strobe, that the write and output strobes never overlap, and that the turnaround follows every read.

Other properties can only be shown by the bench scenarios. These are the exact strobe widths, the returned data and lane masking, the commit of partial-lane writes into a RAM model, and the fact that empty-lane requests leave the memory untouched. The bench tracks them through a scoreboard and a behavioural RAM.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    localparam int LANES = 2;

    typedef enum logic [2:0] {
        IDLE,
        RD_ACTIVE,
        WR_ACTIVE,
        WR_RELEASE,
        TURNAROUND
    } ctrl_state_t;

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign expired = (count_q == '0);
endmodule

// File: rtl/sram_ctrl_lane_mask.sv
module sram_ctrl_lane_mask #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic [LANES*LANE_W-1:0] din,
    input  logic [LANES-1:0]        lane_en,
    output logic [LANES*LANE_W-1:0] dout
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dout[g*LANE_W +: LANE_W] = lane_en[g] ? din[g*LANE_W +: LANE_W] : '0;
    end
endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int CNT_W       = 2,
    parameter int RD_CYCLES   = 2,
    parameter int WR_CYCLES   = 2,
    parameter int TURN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_be,
    input  logic              t_expired,
    input  logic [DATA_W-1:0] rd_masked,
    output logic              t_load,
    output logic [CNT_W-1:0]  t_val,
    output logic              req_ready,
    output logic              ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              we_n,
    output logic              oe_n,
    output logic [LANES-1:0]  lane_n,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out
);
    localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYCLES - 1);
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

    ctrl_state_t state_q, state_d;
    logic        take;

    assign req_ready = (state_q == IDLE);
    assign take      = req_ready && req;

    // next state and timer load
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        unique case (state_q)
            IDLE: begin
                if (take && (req_be != '0)) begin
                    state_d = req_we ? WR_ACTIVE : RD_ACTIVE;
                    t_load  = 1'b1;
                    t_val   = req_we ? WR_LAST : RD_LAST;
                end
            end
            RD_ACTIVE: begin
                if (t_expired) begin
                    state_d = TURNAROUND;
                    t_load  = 1'b1;
                    t_val   = TURN_LAST;
                end
            end
            WR_ACTIVE:  if (t_expired) state_d = WR_RELEASE;
            WR_RELEASE: state_d = IDLE;
            TURNAROUND: if (t_expired) state_d = IDLE;
            default:    state_d = IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IDLE;
        else        state_q <= state_d;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack      <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
            addr     <= '0;
            ce_n     <= 1'b1;
            we_n     <= 1'b1;
            oe_n     <= 1'b1;
            lane_n   <= '1;
            dq_oe    <= 1'b0;
            dq_out   <= '0;
        end else begin
            ack      <= 1'b0;
            rd_valid <= 1'b0;
            unique case (state_q)
                IDLE: begin
                    if (take) begin
                        if (req_be != '0) begin
                            addr   <= req_addr;
                            ce_n   <= 1'b0;
                            lane_n <= ~req_be;
                            if (req_we) begin
                                we_n   <= 1'b0;
                                dq_oe  <= 1'b1;
                                dq_out <= req_wdata;
                            end else begin
                                oe_n <= 1'b0;
                            end
                        end else if (req_we) begin
                            ack <= 1'b1;
                        end else begin
                            rd_valid <= 1'b1;
                            rd_data  <= '0;
                        end
                    end
                end
                RD_ACTIVE: begin
                    if (t_expired) begin
                        rd_valid <= 1'b1;
                        rd_data  <= rd_masked;
                        ce_n     <= 1'b1;
                        oe_n     <= 1'b1;
                        lane_n   <= '1;
                    end
                end
                WR_ACTIVE: begin
                    if (t_expired) we_n <= 1'b1;
                end
                WR_RELEASE: begin
                    ce_n   <= 1'b1;
                    lane_n <= '1;
                    dq_oe  <= 1'b0;
                    ack    <= 1'b1;
                end
                TURNAROUND: begin
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int RD_CYCLES   = 2,
    parameter int WR_CYCLES   = 2,
    parameter int TURN_CYCLES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_be,
    output logic              req_ready,
    output logic              ack,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic              sram_dq_oe,
    output logic [DATA_W-1:0] sram_dq_out,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int LANE_W  = DATA_W / LANES;
    localparam int MAX_A   = (RD_CYCLES > WR_CYCLES) ? RD_CYCLES : WR_CYCLES;
    localparam int MAX_CYC = (MAX_A > TURN_CYCLES) ? MAX_A : TURN_CYCLES;
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    logic             t_load, t_expired;
    logic [CNT_W-1:0] t_val;
    logic [LANES-1:0] lane_n;
    logic [DATA_W-1:0] rd_masked;

    sram_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    sram_ctrl_lane_mask #(.LANES(LANES), .LANE_W(LANE_W)) mask_i (
        .din     (sram_dq_in),
        .lane_en (~lane_n),
        .dout    (rd_masked)
    );

    sram_ctrl_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
        .RD_CYCLES(RD_CYCLES), .WR_CYCLES(WR_CYCLES), .TURN_CYCLES(TURN_CYCLES)
    ) fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_be    (req_be),
        .t_expired (t_expired),
        .rd_masked (rd_masked),
        .t_load    (t_load),
        .t_val     (t_val),
        .req_ready (req_ready),
        .ack       (ack),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .addr      (sram_addr),
        .ce_n      (sram_ce_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .lane_n    (lane_n),
        .dq_oe     (sram_dq_oe),
        .dq_out    (sram_dq_out)
    );

    assign sram_lb_n = lane_n[0];
    assign sram_ub_n = lane_n[1];
endmodule

// File: rtl/sram_bus_ctrl_chk.sv
module sram_bus_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              ack,
    input logic              rd_valid,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_we_n,
    input logic              sram_oe_n,
    input logic              sram_lb_n,
    input logic              sram_ub_n,
    input logic              sram_dq_oe,
    input logic [DATA_W-1:0] sram_dq_out
);
    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !(sram_dq_oe && !sram_oe_n)); // R7

    AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> sram_ce_n); // R2

    AST_LANES_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_lb_n && sram_ub_n)); // R5

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!sram_we_n && !sram_oe_n)); // R3

    AST_WE_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_dq_out)
                              && sram_dq_oe && !sram_ce_n)); // R4

    AST_READ_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_oe_n) |-> !req_ready); // R8

    AST_SINGLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && rd_valid)); // R4
endmodule

bind sram_bus_ctrl sram_bus_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .ack         (ack),
    .rd_valid    (rd_valid),
    .sram_addr   (sram_addr),
    .sram_ce_n   (sram_ce_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_lb_n   (sram_lb_n),
    .sram_ub_n   (sram_ub_n),
    .sram_dq_oe  (sram_dq_oe),
    .sram_dq_out (sram_dq_out)
);

// File: tb/sram_bus_ctrl_tb_top.sv
module sram_bus_ctrl_tb_top;
    localparam int RD_CYC   = 2;
    localparam int WR_CYC   = 2;
    localparam int TURN_CYC = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, ack, rd_valid;
    logic [15:0] rd_data, sram_addr, sram_dq_out, sram_dq_in;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, sram_dq_oe;

    always #4 clk = ~clk;

    sram_bus_ctrl #(.RD_CYCLES(RD_CYC), .WR_CYCLES(WR_CYC), .TURN_CYCLES(TURN_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready), .ack(ack),
        .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
        .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n), .sram_dq_oe(sram_dq_oe),
        .sram_dq_out(sram_dq_out), .sram_dq_in(sram_dq_in)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req_id, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req_id, what, act, exp);
        end
    endtask

    // behavioural RAM
    logic [15:0] mem [int];

    function automatic logic [15:0] ram_word(input logic [15:0] a);
        return mem.exists(int'(a)) ? mem[int'(a)] : (a ^ 16'h3C3C);
    endfunction

    always_comb begin
        logic [15:0] w;
        w = ram_word(sram_addr);
        if (!sram_ce_n && !sram_oe_n && sram_we_n) begin
            sram_dq_in[7:0]  = sram_lb_n ? 8'hA5 : w[7:0];
            sram_dq_in[15:8] = sram_ub_n ? 8'h5A : w[15:8];
        end else begin
            sram_dq_in = 16'hFFFF;
        end
    end

    always @(posedge sram_we_n) begin
        if (rst_n && sram_ce_n === 1'b0) begin
            logic [15:0] w;
            w = ram_word(sram_addr);
            if (!sram_lb_n) w[7:0]  = sram_dq_out[7:0];
            if (!sram_ub_n) w[15:8] = sram_dq_out[15:8];
            mem[int'(sram_addr)] = w;
        end
    end

    // bench shadow of the RAM contents
    logic [15:0] shadow [int];

    function automatic logic [15:0] shadow_word(input logic [15:0] a);
        return shadow.exists(int'(a)) ? shadow[int'(a)] : (a ^ 16'h3C3C);
    endfunction

    typedef struct packed {
        logic        is_rd;
        logic [15:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   ops_done = 0;
    int   oe_low_total = 0;
    int   we_low_total = 0;
    int   cyc = 0;
    int   last_oe_low = -100;
    int   oe_run = 0;
    int   we_run = 0;
    logic prev_dq_oe = 1'b0;
    logic prev_ce_n = 1'b1;
    logic [1:0] cur_be = '0;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (ack || rd_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected result", {31'd0, rd_valid}, 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rd_valid == e.is_rd && ack == !e.is_rd, "R4",
                          "result kind", {30'd0, ack, rd_valid}, {30'd0, !e.is_rd, e.is_rd});
                    if (e.is_rd)
                        check(rd_data == e.data, "R6", "read data", rd_data, e.data);
                end
                ops_done++;
            end
            if (req_ready && !sram_ce_n)
                check(1'b0, "R2", "ce low while idle", 32'd0, 32'd1);
            if (sram_dq_oe && !sram_oe_n)
                check(1'b0, "R7", "driver on with oe low", 32'd1, 32'd0);
            if (!sram_ce_n && prev_ce_n)
                check({sram_ub_n, sram_lb_n} == ~cur_be, "R5", "lane strobes",
                      {30'd0, sram_ub_n, sram_lb_n}, {30'd0, ~cur_be});
            if (!sram_oe_n) begin
                oe_run++;
                oe_low_total++;
                last_oe_low = cyc;
            end else if (oe_run > 0) begin
                check(oe_run == RD_CYC, "R3", "oe low width", oe_run, RD_CYC);
                oe_run = 0;
            end
            if (!sram_we_n) begin
                we_run++;
                we_low_total++;
            end else if (we_run > 0) begin
                check(we_run == WR_CYC, "R4", "we low width", we_run, WR_CYC);
                we_run = 0;
            end
            if (sram_dq_oe && !prev_dq_oe && last_oe_low > 0)
                check(cyc - last_oe_low - 1 >= TURN_CYC + 1, "R8", "turnaround gap",
                      cyc - last_oe_low - 1, TURN_CYC + 1);
            prev_dq_oe = sram_dq_oe;
            prev_ce_n  = sram_ce_n;
        end
    end

    // driver
    task automatic do_op(input bit we, input logic [15:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        exp_t e;
        int   target;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        cur_be = be;
        e.is_rd = !we;
        e.data  = '0;
        if (we) begin
            logic [15:0] w;
            w = shadow_word(a);
            if (be[0]) w[7:0]  = d[7:0];
            if (be[1]) w[15:8] = d[15:8];
            shadow[int'(a)] = w;
        end else begin
            logic [15:0] w;
            w = shadow_word(a);
            e.data = {be[1] ? w[15:8] : 8'h00, be[0] ? w[7:0] : 8'h00};
        end
        exp_q.push_back(e);
        target = ops_done + 1;
        @(posedge clk);
        #1 req = 1'b0;
        wait (ops_done == target);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sram_ce_n && sram_we_n && sram_oe_n && sram_lb_n && sram_ub_n,
              "R1", "strobes in reset", {27'd0, sram_ce_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n},
              32'h1F);
        check(!sram_dq_oe && req_ready, "R1", "driver/ready in reset",
              {30'd0, sram_dq_oe, req_ready}, 32'd1);
        rst_n = 1'b1;

        do_op(1'b1, 16'h0000, 16'h1234, 2'b11);  // R4 full write
        do_op(1'b0, 16'h0000, 16'h0000, 2'b11);  // R3 full read
        do_op(1'b1, 16'hFFFF, 16'hBEEF, 2'b11);  // R4 top address
        do_op(1'b1, 16'hFFFF, 16'h00CC, 2'b01);  // R5 low lane only
        do_op(1'b0, 16'hFFFF, 16'h0000, 2'b11);  // R5 expect BECC
        do_op(1'b1, 16'h0040, 16'h7700, 2'b10);  // R5 high lane only
        do_op(1'b0, 16'h0040, 16'h0000, 2'b11);
        do_op(1'b0, 16'h0040, 16'h0000, 2'b01);  // R6 upper forced zero
        do_op(1'b0, 16'hFFFF, 16'h0000, 2'b10);  // R6 lower forced zero

        begin // R9 empty-lane write
            int we_before;
            we_before = we_low_total;
            do_op(1'b1, 16'h0000, 16'hDEAD, 2'b00);
            check(we_low_total == we_before, "R9", "we asserted on empty write",
                  we_low_total - we_before, 0);
            do_op(1'b0, 16'h0000, 16'h0000, 2'b11);  // R9 contents unchanged
        end
        begin // R10 empty-lane read
            int oe_before;
            oe_before = oe_low_total;
            do_op(1'b0, 16'h1111, 16'h0000, 2'b00);
            check(oe_low_total == oe_before, "R10", "oe asserted on empty read",
                  oe_low_total - oe_before, 0);
        end
        // R8 read immediately followed by write
        do_op(1'b0, 16'h0123, 16'h0000, 2'b11);
        do_op(1'b1, 16'h0123, 16'hA0A0, 2'b11);
        do_op(1'b0, 16'h0123, 16'h0000, 2'b11);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3", "outstanding results", exp_q.size(), 0);
        check(req_ready && sram_ce_n, "R2", "idle standby at end",
              {30'd0, req_ready, sram_ce_n}, 32'd3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "R3", "watchdog expired", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule